// File: doc/BRIEF.md
# Shared-Logic Carry-Select Adder

This block is a purely combinational adder of two unsigned operands, 10 bits wide by default. It produces the sum and a carry-out. Its intended place is the last stage of a small multiplier, where two compressed partial-product rows are reduced to the final product. It has no clock and no state, so a result is valid once the inputs have settled through its gates.

The word is cut into segments. The lowest segment is a single lookahead adder whose carry-in is tied to zero. Every higher segment computes, once, the bitwise propagate and generate terms and a lookahead carry chain that assumes a carry-in of zero. The carries for an assumed carry-in of one are then formed by OR-ing each zero-assumption carry with the AND of all propagates from the segment base up to that bit. The real carry arriving from the segment below picks one of the two results, sum bits and segment carry together, through a word-wide 2-to-1 selector.

A parameter restores the textbook form, with an independent second lookahead chain per segment, for comparison. The segment widths are parameters as well.

Top module: `cs_share_adder`

## Requirements
- R1: For every pair of operands, {cout_o, sum_o} equals the 11-bit unsigned sum of x_i and y_i.
- R2: With the defaults, the segments cover bits [2:0], [5:3] and [9:6]. A carry generated at the top bit of one segment (bits 2 and 5) reaches the next segment and gives the exact sum.
- R3: The lowest segment adds with no injected carry. 0 + 0 gives sum 0 and carry-out 0, and any value plus 0 returns that value with carry-out 0.
- R4: In each upper segment, the carry-in-1 result {segment carry, segment sum} equals the carry-in-0 result plus one. An incoming carry that ripples through a fully propagating segment (all ones plus one) gives sum 0 and carry-out 1.
- R5: cout_o is the carry out of the top segment [9:6]. It can be 1 only when bit 9 of x_i or of y_i is 1. 0x200 + 0x200 gives sum 0 with carry-out 1, and 0x3FF + 0x3FF gives 0x3FE with carry-out 1.
- R6: The result does not depend on operand order: swapping x_i and y_i leaves sum_o and cout_o unchanged.
- R7: Alternating bit patterns add exactly. 0x155 + 0x2AA gives 0x3FF with carry-out 0, and 0x2AA + 0x2AA gives 0x154 with carry-out 1.
- R8: The variant with SHARE_C1 = 0, which uses a separate carry-in-1 lookahead chain, gives results identical to the shared variant for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W (10) | First addend |
| y_i | input | W (10) | Second addend |
| sum_o | output | W (10) | Sum, modulo 2^W |
| cout_o | output | 1 | Carry out of the most significant segment |

## Verification
The case hardest to reach from the ports is a selected carry-in-1 path that is itself all-propagate. In that case the derived carry rests entirely on the AND-prefix of propagates rather than on any generate term. Random operands make every bit of a segment propagate together only rarely.

Directed vectors force this case. They include all ones plus one, values that end in a carry out of bit 2 or bit 5 into a segment of ones, and alternating patterns. Several thousand seeded random pairs then cover the mixed generate and propagate cases.

// File: rtl/csel_pkg.sv
package csel_pkg;

   // number of carry-selected segments above the low lookahead segment
   function automatic int unsigned sel_count(int unsigned w, int unsigned lo_w, int unsigned sw);
      return (w - lo_w) / sw;
   endfunction

   // least significant bit of selected segment i
   function automatic int unsigned sel_base(int unsigned lo_w, int unsigned sw, int unsigned i);
      return lo_w + i * sw;
   endfunction

   // width of selected segment i; the last one absorbs the remainder
   function automatic int unsigned sel_width(int unsigned w, int unsigned lo_w, int unsigned sw,
                                             int unsigned i, int unsigned n);
      if (i == n - 1)
         return w - lo_w - (n - 1) * sw;
      else
         return sw;
   endfunction

endpackage

// File: rtl/csel_pg_bits.sv
module csel_pg_bits #(
   parameter int unsigned W = 10
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] prop_o,
   output logic [W-1:0] gen_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("csel_pg_bits: W must be at least 1");
      end
   endgenerate

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign prop_o[k] = a_i[k] ^ b_i[k];
      assign gen_o[k]  = a_i[k] & b_i[k];
   end

endmodule

// File: rtl/csel_low_cla.sv
module csel_low_cla #(
   parameter int unsigned SW = 3
) (
   input  logic [SW-1:0] prop_i,
   input  logic [SW-1:0] gen_i,
   output logic [SW-1:0] sum_o,
   output logic          cout_o
);

   logic [SW-1:0] cy;

   generate
      if (SW < 1) begin : g_bad_sw
         $error("csel_low_cla: SW must be at least 1");
      end
   endgenerate

   // carry-in fixed at zero: first carry is the lowest generate
   assign cy[0]    = gen_i[0];
   assign sum_o[0] = prop_i[0];

   for (genvar k = 1; k < SW; k++) begin : g_chain
      assign cy[k]    = gen_i[k] | (prop_i[k] & cy[k-1]);
      assign sum_o[k] = prop_i[k] ^ cy[k-1];
   end

   assign cout_o = cy[SW-1];

   always_comb begin
      assert ({cout_o, sum_o} == ({1'b0, prop_i} + {gen_i, 1'b0}))
         else $error("low segment sum mismatch"); // AST_LOW_EXACT R3
   end

endmodule

// File: rtl/csel_share_seg.sv
module csel_share_seg #(
   parameter int unsigned SW       = 3,
   parameter bit          SHARE_C1 = 1'b1
) (
   input  logic [SW-1:0] prop_i,
   input  logic [SW-1:0] gen_i,
   input  logic          cin_i,
   output logic [SW-1:0] sum_o,
   output logic          cout_o
);

   logic [SW-1:0] c0;
   logic [SW-1:0] c1;
   logic [SW-1:0] s0;
   logic [SW-1:0] s1;

   generate
      if (SW < 1) begin : g_bad_sw
         $error("csel_share_seg: SW must be at least 1");
      end
   endgenerate

   // carry-in-0 chain
   assign c0[0] = gen_i[0];
   for (genvar k = 1; k < SW; k++) begin : g_c0
      assign c0[k] = gen_i[k] | (prop_i[k] & c0[k-1]);
   end

   // carry-in-1 chain: shared or duplicated variant
   generate
      if (SHARE_C1) begin : g_shared
         for (genvar k = 0; k < SW; k++) begin : g_c1
            assign c1[k] = c0[k] | (&prop_i[k:0]);
         end
      end else begin : g_dup
         assign c1[0] = gen_i[0] | prop_i[0];
         for (genvar k = 1; k < SW; k++) begin : g_c1
            assign c1[k] = gen_i[k] | (prop_i[k] & c1[k-1]);
         end
      end
   endgenerate

   // sums for both hypotheses
   assign s0[0] = prop_i[0];
   assign s1[0] = ~prop_i[0];
   for (genvar k = 1; k < SW; k++) begin : g_sum
      assign s0[k] = prop_i[k] ^ c0[k-1];
      assign s1[k] = prop_i[k] ^ c1[k-1];
   end

   // word-level selector driven by the incoming carry
   assign {cout_o, sum_o} = cin_i ? {c1[SW-1], s1} : {c0[SW-1], s0};

   always_comb begin
      assert ({c1[SW-1], s1} == ({c0[SW-1], s0} + (SW+1)'(1)))
         else $error("carry-in-1 result is not carry-in-0 result plus one"); // AST_SEL_PLUS_ONE R4
   end

endmodule

// File: rtl/cs_share_adder.sv
module cs_share_adder #(
   parameter int unsigned W        = 10,
   parameter int unsigned LOW_W    = 3,
   parameter int unsigned SEL_W    = 3,
   parameter bit          SHARE_C1 = 1'b1
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   localparam int unsigned NSEL = csel_pkg::sel_count(W, LOW_W, SEL_W);

   generate
      if (LOW_W < 1 || SEL_W < 1) begin : g_bad_seg
         $error("cs_share_adder: segment widths must be at least 1");
      end
      if (W < LOW_W + SEL_W) begin : g_bad_w
         $error("cs_share_adder: W must hold the low segment and one selected segment");
      end
   endgenerate

   logic [W-1:0]  prop;
   logic [W-1:0]  gen;
   logic [NSEL:0] seg_c;

   csel_pg_bits #(.W(W)) u_pg (
      .a_i    (x_i),
      .b_i    (y_i),
      .prop_o (prop),
      .gen_o  (gen)
   );

   csel_low_cla #(.SW(LOW_W)) u_low (
      .prop_i (prop[LOW_W-1:0]),
      .gen_i  (gen[LOW_W-1:0]),
      .sum_o  (sum_o[LOW_W-1:0]),
      .cout_o (seg_c[0])
   );

   for (genvar i = 0; i < NSEL; i++) begin : g_seg
      localparam int unsigned B  = csel_pkg::sel_base(LOW_W, SEL_W, i);
      localparam int unsigned SW = csel_pkg::sel_width(W, LOW_W, SEL_W, i, NSEL);
      csel_share_seg #(.SW(SW), .SHARE_C1(SHARE_C1)) u_seg (
         .prop_i (prop[B +: SW]),
         .gen_i  (gen[B +: SW]),
         .cin_i  (seg_c[i]),
         .sum_o  (sum_o[B +: SW]),
         .cout_o (seg_c[i+1])
      );
   end

   assign cout_o = seg_c[NSEL];

   always_comb begin
      assert ({cout_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i}))
         else $error("adder result mismatch"); // AST_SUM_MATCH R1
      assert (!cout_o || x_i[W-1] || y_i[W-1])
         else $error("carry-out without an MSB set"); // AST_COUT_NEEDS_MSB R5
   end

endmodule

// File: tb/cs_share_adder_bench.sv
module cs_share_adder_bench;

   localparam int unsigned W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] x, y;
   logic [W-1:0] sum_s, sum_d;
   logic         co_s, co_d;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   cs_share_adder #(.W(W)) u_cs_share_adder (
      .x_i(x), .y_i(y), .sum_o(sum_s), .cout_o(co_s));

   cs_share_adder #(.W(W), .SHARE_C1(1'b0)) u_cs_share_adder_dup (
      .x_i(x), .y_i(y), .sum_o(sum_d), .cout_o(co_d));

   function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b);
      return {1'b0, a} + {1'b0, b};
   endfunction

   task automatic check(string req, logic [W:0] got, logic [W:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s x=%h y=%h got=%h exp=%h", req, x, y, got, exp);
      end
   endtask

   // drive after a rising edge, check at the following falling edge
   task automatic apply(string req, logic [W-1:0] a, logic [W-1:0] b);
      @(posedge clk);
      x = a;
      y = b;
      @(negedge clk);
      check(req, {co_s, sum_s}, ref_add(a, b));
      check("R8", {co_d, sum_d}, {co_s, sum_s});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      x = '0;
      y = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", {co_s, sum_s}, 11'h000);                 // R3 zero plus zero

      apply("R3", 10'h2B7, 10'h000);                        // R3 value plus zero
      apply("R2", 10'h007, 10'h001);                        // R2 carry out of bit 2
      apply("R2", 10'h03F, 10'h001);                        // R2 carry out of bit 5
      apply("R2", 10'h004, 10'h03C);                        // R2 bit-2 carry into ones
      apply("R4", 10'h3FF, 10'h001);                        // R4 all ones plus one
      check("R4", {co_s, sum_s}, 11'h400);
      apply("R4", 10'h1F8, 10'h008);                        // R4 propagating upper segments
      apply("R5", 10'h200, 10'h200);
      check("R5", {co_s, sum_s}, 11'h400);
      apply("R5", 10'h3FF, 10'h3FF);
      check("R5", {co_s, sum_s}, 11'h7FE);
      apply("R7", 10'h155, 10'h2AA);
      check("R7", {co_s, sum_s}, 11'h3FF);
      apply("R7", 10'h2AA, 10'h2AA);
      check("R7", {co_s, sum_s}, 11'h554);
      apply("R7", 10'h155, 10'h155);

      void'($urandom(32'h5EED_0A1D));
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] a, b;
         logic [W:0]   first;
         a = W'($urandom);
         b = W'($urandom);
         if (i % 5 == 0) b = ~a ^ W'(1 << ($urandom % W));  // mostly propagate
         apply("R1", a, b);
         first = {co_s, sum_s};
         apply("R6", b, a);                                 // R6 swapped order
         check("R6", {co_s, sum_s}, first);
      end

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog got=expired exp=complete");
         finish_run();
      end
   end

endmodule